// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt RAM

This block is a 2048-word by 8-bit storage array with two fully independent access ports, a left one and a right one. Each port has an active-low chip enable, a read/write select (high reads, low writes), an active-low output enable, an 11-bit address, write data and registered read data. Both ports are sampled on one shared clock edge. A read returns the addressed word on the read-data output one cycle after the address is presented. A deselected port does nothing and its read data holds.

The two highest addresses also act as cross-port mailboxes. Each port owns an active-low interrupt output. The right port raises the left port's interrupt by writing word 0x7FE. The left port raises the right port's interrupt by writing word 0x7FF. The owning port clears its interrupt by touching its mailbox address with both chip enable and output enable low; the read/write level does not matter for the clear. The mailbox words stay ordinary storage, so the message carried there is the user's choice. A parameter removes the mailbox function. The interrupts then stay inactive and the two top words are plain memory.

Top module: `dpmb_ram`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, both interrupt outputs are high (inactive) and both read-data outputs are 0.
- R2: A port with chip enable low and read/write high at a clock edge shows the word at its address on its read data after that edge.
- R3: A port with chip enable low and read/write low at a clock edge stores its write data at its address, and either port can later read that word.
- R4: A port with chip enable high performs no access: it writes nothing, its read data holds, and it cannot clear its interrupt.
- R5: A write by the right port to address 0x7FE drives the left interrupt output low after that edge.
- R6: The left interrupt returns high after an edge where the left port has chip enable low, output enable low and address 0x7FE, whatever its read/write level; with output enable high the interrupt stays low.
- R7: A write by the left port to address 0x7FF drives the right interrupt output low after that edge.
- R8: The right interrupt returns high after an edge where the right port has chip enable low, output enable low and address 0x7FF, whatever its read/write level; with output enable high it stays low.
- R9: When a flag's set and clear happen at the same edge, the flag ends up set (output low).
- R10: Words 0x7FE and 0x7FF store and return data like any other address.
- R11: With the mailbox parameter disabled, both interrupt outputs stay high at all times, and 0x7FE and 0x7FF act as plain memory.
- R12: When both ports write the same address at the same edge, the left port's data is kept.
- R13: A read at the same edge as a write to the same address by the other port returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; both ports sample on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read/write select, high reads, low writes |
| l_oe_n | input | 1 | Left output enable, active low, used for the mailbox clear |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write select, high reads, low writes |
| r_oe_n | input | 1 | Right output enable, active low, used for the mailbox clear |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds two copies side by side from the same stimulus. One copy uses the default parameters with the mailbox enabled. The other has the mailbox parameter turned off, so its interrupts must never move while its read data must still match the first copy word for word, including at 0x7FE and 0x7FF. Both copies keep the full 11-bit address, so the real mailbox addresses, the same-address write collision and the read-before-write ordering are all driven at their true positions.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    // Decoded intent of one port for the current cycle.
    typedef struct packed {
        logic wr_en;      // selected and writing
        logic rd_en;      // selected and reading
        logic peer_hit;   // writing the partner's mailbox word
        logic own_touch;  // touching its own mailbox with output enable low
    } port_ctl_t;

    // Interrupt flag state.
    typedef struct packed {
        logic pend;
    } flag_t;

endpackage

// File: rtl/dpmb_port_ctl.sv
module dpmb_port_ctl
    import dpmb_pkg::*;
#(
    parameter int              ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] OWN_MB  = '1,
    parameter logic [ADDR_W-1:0] PEER_MB = '1
) (
    input  logic              ce_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output port_ctl_t         ctl
);

    logic sel;

    always_comb begin
        sel           = ~ce_n;
        ctl.wr_en     = sel & ~rw_n;
        ctl.rd_en     = sel &  rw_n;
        ctl.peer_hit  = ctl.wr_en & (addr == PEER_MB);
        ctl.own_touch = sel & ~oe_n & (addr == OWN_MB);
    end

endmodule

// File: rtl/dpmb_irq_flag.sv
module dpmb_irq_flag
    import dpmb_pkg::*;
#(
    parameter bit EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic int_n
);

    flag_t flag_d, flag_q;
    logic  set_g;

    always_comb begin
        set_g  = set & EN;
        flag_d = flag_q;
        if (clr)   flag_d.pend = 1'b0;
        if (set_g) flag_d.pend = 1'b1;   // set has priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign int_n = ~flag_q.pend;

endmodule

// File: rtl/dpmb_store.sv
module dpmb_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             wr_en,
    input  logic [1:0]             rd_en,
    input  logic [1:0][ADDR_W-1:0] addr,
    input  logic [1:0][DATA_W-1:0] wdata,
    output logic [1:0][DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [1:0][DATA_W-1:0] rd;
    } rd_state_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_state_t         rd_d, rd_q;

    // Reads see the array as it stood before this edge's writes.
    always_comb begin
        rd_d = rd_q;
        for (int p = 0; p < 2; p++) begin
            if (rd_en[p]) rd_d.rd[p] = mem_q[addr[p]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // Port 0 (left) is applied last, so it wins a same-address collision.
    always_ff @(posedge clk) begin
        for (int p = 1; p >= 0; p--) begin
            if (wr_en[p]) mem_q[addr[p]] <= wdata[p];
        end
    end

    assign rdata = rd_q.rd;

endmodule

// File: rtl/dpmb_ram.sv
module dpmb_ram
    import dpmb_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter bit MAILBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_int_n,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_int_n
);

    localparam logic [ADDR_W-1:0] MB_RIGHT = '1;            // right port's mailbox
    localparam logic [ADDR_W-1:0] MB_LEFT  = MB_RIGHT - 1'b1; // left port's mailbox

    // Index 0 = left, 1 = right.
    logic [1:0]             ce_n, rw_n, oe_n;
    logic [1:0][ADDR_W-1:0] addr;
    logic [1:0][DATA_W-1:0] wdata, rdata;
    logic [1:0]             wr_en, rd_en, int_n;
    port_ctl_t              ctl [2];

    assign ce_n  = {r_ce_n, l_ce_n};
    assign rw_n  = {r_rw_n, l_rw_n};
    assign oe_n  = {r_oe_n, l_oe_n};
    assign addr  = {r_addr, l_addr};
    assign wdata = {r_wdata, l_wdata};

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? MB_LEFT  : MB_RIGHT;
        localparam logic [ADDR_W-1:0] PEER = (s == 0) ? MB_RIGHT : MB_LEFT;

        dpmb_port_ctl #(
            .ADDR_W  (ADDR_W),
            .OWN_MB  (OWN),
            .PEER_MB (PEER)
        ) u_ctl (
            .ce_n (ce_n[s]),
            .rw_n (rw_n[s]),
            .oe_n (oe_n[s]),
            .addr (addr[s]),
            .ctl  (ctl[s])
        );

        assign wr_en[s] = ctl[s].wr_en;
        assign rd_en[s] = ctl[s].rd_en;

        // A side's flag is set by the other side writing this side's mailbox.
        dpmb_irq_flag #(
            .EN (MAILBOX_EN)
        ) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (ctl[1-s].peer_hit),
            .clr   (ctl[s].own_touch),
            .int_n (int_n[s])
        );
    end

    dpmb_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign l_rdata = rdata[0];
    assign r_rdata = rdata[1];
    assign l_int_n = int_n[0];
    assign r_int_n = int_n[1];

endmodule

// File: rtl/dpmb_ram_chk.sv
module dpmb_ram_chk #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter bit MAILBOX_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_int_n,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_int_n
);

    localparam logic [ADDR_W-1:0] MB_R = '1;
    localparam logic [ADDR_W-1:0] MB_L = MB_R - 1'b1;

    logic set_l, set_r, clr_l, clr_r;
    assign set_l = MAILBOX_EN && !r_ce_n && !r_rw_n && (r_addr == MB_L);
    assign set_r = MAILBOX_EN && !l_ce_n && !l_rw_n && (l_addr == MB_R);
    assign clr_l = !l_ce_n && !l_oe_n && (l_addr == MB_L);
    assign clr_r = !r_ce_n && !r_oe_n && (r_addr == MB_R);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (l_int_n && r_int_n && l_rdata == '0 && r_rdata == '0));

    // R5
    l_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !l_int_n);

    // R7
    r_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !r_int_n);

    // R6
    l_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> l_int_n);

    // R8
    r_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> r_int_n);

    // R5
    l_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_int_n) |-> $past(set_l));

    // R7
    r_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_int_n) |-> $past(set_r));

    // R4
    l_standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_ce_n |=> $stable(l_rdata));

    // R4
    r_standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_ce_n |=> $stable(r_rdata));

    // R11
    plain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !MAILBOX_EN |-> (l_int_n && r_int_n));

endmodule

bind dpmb_ram dpmb_ram_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAILBOX_EN (MAILBOX_EN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce_n  (l_ce_n),
    .l_rw_n  (l_rw_n),
    .l_oe_n  (l_oe_n),
    .l_addr  (l_addr),
    .l_rdata (l_rdata),
    .l_int_n (l_int_n),
    .r_ce_n  (r_ce_n),
    .r_rw_n  (r_rw_n),
    .r_oe_n  (r_oe_n),
    .r_addr  (r_addr),
    .r_rdata (r_rdata),
    .r_int_n (r_int_n)
);

// File: tb/dpmb_ram_test.sv
module dpmb_ram_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    typedef struct packed {
        logic [3:0]  req;
        logic        lce, lrw, loe;
        logic [10:0] la;
        logic [7:0]  lw;
        logic        rce, rrw, roe;
        logic [10:0] ra;
        logic [7:0]  rw;
        logic        clr;
        logic [7:0]  elr;
        logic        crr;
        logic [7:0]  err;
        logic        eli, eri;
    } vec_t;

    // Fields: req | L ce rw oe addr wdata | R ce rw oe addr wdata | chk L exp | chk R exp | exp L int, R int
    localparam vec_t VEC [NV] = '{
        '{4'd3,  1'b0,1'b0,1'b1,11'h005,8'h3C, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1}, // R3 write
        '{4'd2,  1'b0,1'b1,1'b1,11'h005,8'h00, 1'b0,1'b1,1'b1,11'h005,8'h00, 1'b1,8'h3C, 1'b1,8'h3C, 1'b1,1'b1}, // R2 read both
        '{4'd4,  1'b1,1'b0,1'b1,11'h005,8'hFF, 1'b0,1'b0,1'b1,11'h006,8'h5A, 1'b1,8'h3C, 1'b0,8'h00, 1'b1,1'b1}, // R4 standby hold
        '{4'd4,  1'b0,1'b1,1'b1,11'h005,8'h00, 1'b0,1'b1,1'b1,11'h006,8'h00, 1'b1,8'h3C, 1'b1,8'h5A, 1'b1,1'b1}, // R4 no write
        '{4'd5,  1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b0,1'b1,11'h7FE,8'hA1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b1}, // R5 set L
        '{4'd6,  1'b0,1'b1,1'b1,11'h7FE,8'h00, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b1,8'hA1, 1'b0,8'h00, 1'b0,1'b1}, // R6 oe high keeps
        '{4'd6,  1'b0,1'b0,1'b0,11'h7FE,8'h77, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1}, // R6 clear on write
        '{4'd10, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b1,1'b1,11'h7FE,8'h00, 1'b0,8'h00, 1'b1,8'h77, 1'b1,1'b1}, // R10
        '{4'd7,  1'b0,1'b0,1'b1,11'h7FF,8'hC3, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0}, // R7 set R
        '{4'd8,  1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b1,1'b0,11'h7FF,8'h00, 1'b0,8'h00, 1'b1,8'hC3, 1'b1,1'b1}, // R8 clear on read
        '{4'd12, 1'b0,1'b0,1'b1,11'h010,8'h11, 1'b0,1'b0,1'b1,11'h010,8'h22, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1}, // R12 collide
        '{4'd12, 1'b0,1'b1,1'b1,11'h010,8'h00, 1'b0,1'b1,1'b1,11'h010,8'h00, 1'b1,8'h11, 1'b1,8'h11, 1'b1,1'b1}, // R12 left kept
        '{4'd13, 1'b0,1'b0,1'b1,11'h010,8'h99, 1'b0,1'b1,1'b1,11'h010,8'h00, 1'b0,8'h00, 1'b1,8'h11, 1'b1,1'b1}, // R13 old data
        '{4'd13, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b1,1'b1,11'h010,8'h00, 1'b0,8'h00, 1'b1,8'h99, 1'b1,1'b1}, // R13 new data
        '{4'd9,  1'b0,1'b1,1'b0,11'h7FE,8'h00, 1'b0,1'b0,1'b1,11'h7FE,8'h5E, 1'b1,8'h77, 1'b0,8'h00, 1'b0,1'b1}, // R9 set wins L
        '{4'd6,  1'b0,1'b1,1'b0,11'h7FE,8'h00, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b1,8'h5E, 1'b0,8'h00, 1'b1,1'b1}, // R6 clear on read
        '{4'd9,  1'b0,1'b0,1'b1,11'h7FF,8'h12, 1'b0,1'b1,1'b0,11'h7FF,8'h00, 1'b0,8'h00, 1'b1,8'hC3, 1'b1,1'b0}, // R9 set wins R
        '{4'd8,  1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b1,1'b0,11'h7FF,8'h00, 1'b0,8'h00, 1'b1,8'h12, 1'b1,1'b1}, // R8 clear
        '{4'd7,  1'b0,1'b0,1'b1,11'h7FF,8'h34, 1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0}, // R7 set again
        '{4'd8,  1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b1,1'b1,11'h7FF,8'h00, 1'b0,8'h00, 1'b1,8'h34, 1'b1,1'b0}, // R8 oe high keeps
        '{4'd4,  1'b1,1'b1,1'b1,11'h000,8'h00, 1'b1,1'b1,1'b0,11'h7FF,8'h00, 1'b0,8'h00, 1'b1,8'h34, 1'b1,1'b0}, // R4 standby no clear
        '{4'd8,  1'b1,1'b1,1'b1,11'h000,8'h00, 1'b0,1'b0,1'b0,11'h7FF,8'h56, 1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1}  // R8 clear on write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
    logic [10:0] l_addr = '0;
    logic [7:0]  l_wdata = '0;
    logic        r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
    logic [10:0] r_addr = '0;
    logic [7:0]  r_wdata = '0;
    logic [7:0]  l_rdata, r_rdata, p_l_rdata, p_r_rdata;
    logic        l_int_n, r_int_n, p_l_int_n, p_r_int_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpmb_ram uut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
    );

    dpmb_ram #(.MAILBOX_EN(1'b0)) uut_plain (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(p_l_rdata), .l_int_n(p_l_int_n),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(p_r_rdata), .r_int_n(p_r_int_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        l_ce_n = v.lce; l_rw_n = v.lrw; l_oe_n = v.loe; l_addr = v.la; l_wdata = v.lw;
        r_ce_n = v.rce; r_rw_n = v.rrw; r_oe_n = v.roe; r_addr = v.ra; r_wdata = v.rw;
    endtask

    task automatic idle();
        l_ce_n = 1'b1; l_rw_n = 1'b1; l_oe_n = 1'b1;
        r_ce_n = 1'b1; r_rw_n = 1'b1; r_oe_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        #2 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 l_int_n", {7'd0, l_int_n}, 8'h01);
        check("R1 r_int_n", {7'd0, r_int_n}, 8'h01);
        check("R1 l_rdata", l_rdata, 8'h00);
        check("R1 r_rdata", r_rdata, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d v%0d", VEC[i].req, i);
            drive(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check({tag, " l_int_n"}, {7'd0, l_int_n}, {7'd0, VEC[i].eli});
            check({tag, " r_int_n"}, {7'd0, r_int_n}, {7'd0, VEC[i].eri});
            if (VEC[i].clr) begin
                check({tag, " l_rdata"}, l_rdata, VEC[i].elr);
                check({tag, " plain l_rdata"}, p_l_rdata, VEC[i].elr);  // R11 plain memory
            end
            if (VEC[i].crr) begin
                check({tag, " r_rdata"}, r_rdata, VEC[i].err);
                check({tag, " plain r_rdata"}, p_r_rdata, VEC[i].err);  // R11 plain memory
            end
            // R11 disabled mailbox keeps both flags high
            check("R11 plain l_int_n", {7'd0, p_l_int_n}, 8'h01);
            check("R11 plain r_int_n", {7'd0, p_r_int_n}, 8'h01);
        end

        // R5 then R1: reset in mid-run releases a pending flag
        r_ce_n = 1'b0; r_rw_n = 1'b0; r_addr = 11'h7FE; r_wdata = 8'hE1;
        l_ce_n = 1'b0; l_rw_n = 1'b1; l_addr = 11'h005;
        @(posedge clk);
        @(negedge clk);
        check("R5 set before reset", {7'd0, l_int_n}, 8'h00);
        check("R2 read before reset", l_rdata, 8'h3C);
        idle();
        rst_n = 1'b0;
        #1;
        check("R1 mid-run l_int_n", {7'd0, l_int_n}, 8'h01);
        check("R1 mid-run l_rdata", l_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 mailbox word written just before reset survives it
        l_ce_n = 1'b0; l_rw_n = 1'b1; l_oe_n = 1'b1; l_addr = 11'h7FE;
        @(posedge clk);
        @(negedge clk);
        check("R10 mailbox after reset", l_rdata, 8'hE1);
        check("R6 no clear with oe high", {7'd0, l_int_n}, 8'h01);
        idle();

        done = 1'b1;
        finish_run();
    end

endmodule